// File: doc/BRIEF.md
# Burst DMA Bus Master

This block is the master side of a 32-bit bus that carries address and data on the same wires. An internal requester hands it a start address, a direction and a burst-size code. The block then asks for the bus with an active-low request line and waits for the active-low grant. It drives the address for one clock and then moves the data words. Each word completes only when the target pulls its active-low ready line.

A target can abort a tenure with an active-low abort line. The master then releases the bus at once and asks for it again. It resumes at the word that was cut off, with a size code rounded down to the largest supported burst that fits the words still to move. If the rounded burst is shorter than the remainder, further tenures follow until every word has moved. A mode input removes the clock between the address and the first sampled data clock, so ready and abort are seen one clock sooner. A low on the bus-error line halts the master for good: it sets a sticky status bit and raises an interrupt unless the interrupt is masked.

Top module: `dma_burst_master`

## Requirements
- R1: The size output encodes the burst as 000=1, 001=2, 010=4, 011=8, 100=16 and 101=12 words. A requester code of 110 or 111 is run as a single-word transfer with size code 000.
- R2: The direction output is 1 for a read and 0 for a write, and it resets to 1. After reset the request is high, the bus floats, the size code is 000 and the requester may start a transfer.
- R3: The request output goes high on the clock edge after which exactly one word of the current tenure is left. For a one-word tenure it is already high in the address clock.
- R4: The request is raised only after the grant has been seen high. The address clock follows the clock in which the grant is sampled low, and it carries base plus four times the index of the next word.
- R5: A data word completes only on a sampled clock with ready low. A write drives the word for the current index on the bus. A read captures the bus and presents the captured data and its index, with a valid strobe, one clock later.
- R6: Abort low on a sampled data clock completes no word and releases the request and the bus on the next clock. The master then re-requests and drives the address of the interrupted word.
- R7: Ready is ignored in any clock where abort is low.
- R8: Every tenure after the first carries the size code of the largest supported burst that does not exceed the words left. Tenures repeat until all words have moved.
- R9: In normal mode, one clock after the address clock is not sampled for ready or abort. With the early-mode input set, sampling starts in the first clock after the address.
- R10: Bus-error low in any state stops all activity from the next clock: the request stays high and the bus floats until reset. A sticky error bit is set, and the interrupt equals that bit unless the mask input is 1.
- R11: The bus is driven only in the address clock and, for writes, in the clocks after it in the same tenure. It floats at all other times.
- R12: A one-clock done pulse follows the clock in which the final word completes. The requester-ready output is high exactly while the master is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| early_mode | input | 1 | 1 = sample ready and abort one clock sooner |
| err_mask | input | 1 | 1 = keep the error interrupt low |
| req_valid | input | 1 | Requester starts a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 3 | Burst-size code of the transfer |
| req_addr | input | 32 | Byte address of the first word |
| req_ready | output | 1 | Master idle, a request is accepted |
| wd_idx | output | 5 | Index of the word to write |
| wd_data | input | 32 | Write data for wd_idx |
| rd_valid | output | 1 | Read word strobe |
| rd_idx | output | 5 | Index of the read word |
| rd_data | output | 32 | Read word |
| xfer_done | output | 1 | Transfer finished (one clock) |
| bus_req_n | output | 1 | Active-low bus request |
| bus_gnt_n | input | 1 | Active-low grant |
| bus_rdy_n | input | 1 | Active-low target ready |
| bus_abrt_n | input | 1 | Active-low abort |
| bus_err_n | input | 1 | Active-low bus error |
| ad_out | output | 32 | Address/data driven on the bus |
| ad_oe | output | 1 | Bus drive enable |
| ad_in | input | 32 | Address/data read from the bus |
| burst_size | output | 3 | Size code of the current tenure |
| dir_rd | output | 1 | Direction, 1 = read |
| err_status | output | 1 | Sticky bus-error bit |
| irq | output | 1 | Error interrupt |

## Verification
Abort and ready can both be low in the same sampled data clock. In that clock the abort must win, and no word may be counted. The bench provokes this on purpose at the first, a middle and the last word of bursts, in both directions and both sampling modes. It judges the outcome at the ports: a read must raise no valid strobe, and the resumed address and size code must still name the interrupted word. The drop of the request one word early can also fall in the clock a word completes, and it is checked in every data clock against the bench's own count of the words left.

// File: rtl/dma_burst_master.sv
module dma_burst_master #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          early_mode,
  input  logic          err_mask,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_code,
  input  logic [DW-1:0] req_addr,
  output logic          req_ready,
  output logic [4:0]    wd_idx,
  input  logic [DW-1:0] wd_data,
  output logic          rd_valid,
  output logic [4:0]    rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          xfer_done,
  output logic          bus_req_n,
  input  logic          bus_gnt_n,
  input  logic          bus_rdy_n,
  input  logic          bus_abrt_n,
  input  logic          bus_err_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [2:0]    burst_size,
  output logic          dir_rd,
  output logic          err_status,
  output logic          irq
);
  localparam int MAXW = 16;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_REQ, S_ADDR, S_WAIT, S_DATA, S_HALT} st_t;

  st_t           state;
  logic [DW-1:0] base;
  logic [CW-1:0] idx, left, chunk;
  logic [DW-1:0] cur_addr;
  logic          own;

  function automatic logic [CW-1:0] code_len(input logic [2:0] c);
    case (c)
      3'd1:    code_len = CW'(2);
      3'd2:    code_len = CW'(4);
      3'd3:    code_len = CW'(8);
      3'd4:    code_len = CW'(16);
      3'd5:    code_len = CW'(12);
      default: code_len = CW'(1);
    endcase
  endfunction

  function automatic logic [2:0] fit_code(input logic [CW-1:0] n);
    if (n >= CW'(16))      fit_code = 3'd4;
    else if (n >= CW'(12)) fit_code = 3'd5;
    else if (n >= CW'(8))  fit_code = 3'd3;
    else if (n >= CW'(4))  fit_code = 3'd2;
    else if (n >= CW'(2))  fit_code = 3'd1;
    else                   fit_code = 3'd0;
  endfunction

  assign cur_addr  = base + (DW'(idx) << 2);
  assign own       = (state == S_ADDR) || (state == S_WAIT) || (state == S_DATA);
  assign req_ready = (state == S_IDLE);
  assign bus_req_n = !((state == S_REQ) || (own && chunk != CW'(1)));
  assign ad_oe     = (state == S_ADDR) || (!dir_rd && ((state == S_WAIT) || (state == S_DATA)));
  assign ad_out    = (state == S_ADDR) ? cur_addr : (ad_oe ? wd_data : '0);
  assign wd_idx    = idx;
  assign irq       = err_status && !err_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      base       <= '0;
      idx        <= '0;
      left       <= '0;
      chunk      <= '0;
      burst_size <= 3'd0;
      dir_rd     <= 1'b1;
      err_status <= 1'b0;
      rd_valid   <= 1'b0;
      rd_idx     <= '0;
      rd_data    <= '0;
      xfer_done  <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      xfer_done <= 1'b0;
      if (!bus_err_n) begin
        state      <= S_HALT;
        err_status <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (req_valid) begin
            base   <= req_addr;
            idx    <= '0;
            left   <= code_len(req_code);
            dir_rd <= !req_write;
            state  <= S_PEND;
          end
          S_PEND: begin
            chunk      <= code_len(fit_code(left));
            burst_size <= fit_code(left);
            if (bus_gnt_n) state <= S_REQ;
          end
          S_REQ:  if (!bus_gnt_n) state <= S_ADDR;
          S_ADDR: state <= early_mode ? S_DATA : S_WAIT;
          S_WAIT: state <= S_DATA;
          S_DATA: begin
            if (!bus_abrt_n) begin
              state <= S_PEND;
            end else if (!bus_rdy_n) begin
              idx   <= idx + CW'(1);
              left  <= left - CW'(1);
              chunk <= chunk - CW'(1);
              if (dir_rd) begin
                rd_valid <= 1'b1;
                rd_idx   <= idx;
                rd_data  <= ad_in;
              end
              if (chunk == CW'(1)) begin
                if (left == CW'(1)) begin
                  state     <= S_IDLE;
                  xfer_done <= 1'b1;
                end else begin
                  state <= S_PEND;
                end
              end
            end
          end
          default: state <= S_HALT;
        endcase
      end
    end
  end

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) burst_size <= 3'd5); // R1
  AST_REQ_DROP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && bus_err_n && bus_abrt_n && !bus_rdy_n && chunk == CW'(2)) |=> bus_req_n); // R3
  AST_NO_REQ_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PEND && !bus_gnt_n && bus_err_n) |=> bus_req_n); // R4
  AST_ADDR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REQ && !bus_gnt_n && bus_err_n) |=> (ad_oe && ad_out == cur_addr)); // R4
  AST_ABORT_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && bus_err_n && !bus_abrt_n) |=> (idx == $past(idx) && bus_req_n && !ad_oe && !rd_valid)); // R7
  AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) !bus_err_n |=> err_status); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_status |=> err_status); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) err_status |-> (bus_req_n && !ad_oe)); // R10
endmodule

// File: tb/tb_dma_burst_master.sv
`timescale 1ns/1ps
module tb_dma_burst_master;
  localparam logic [31:0] BASE = 32'h0001_0F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        early_mode = 1'b0, err_mask = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_code = 3'd0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic [4:0]  wd_idx;
  logic [31:0] wd_data;
  logic        rd_valid;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        xfer_done, bus_req_n;
  logic        bus_gnt_n = 1'b1, bus_rdy_n = 1'b1, bus_abrt_n = 1'b1, bus_err_n = 1'b1;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [31:0] ad_in = '0;
  logic [2:0]  burst_size;
  logic        dir_rd, err_status, irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign wd_data = 32'hA500_0000 + {27'd0, wd_idx};

  dma_burst_master dut (
    .clk(clk), .rst_n(rst_n), .early_mode(early_mode), .err_mask(err_mask),
    .req_valid(req_valid), .req_write(req_write), .req_code(req_code), .req_addr(req_addr),
    .req_ready(req_ready), .wd_idx(wd_idx), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .xfer_done(xfer_done),
    .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n), .bus_rdy_n(bus_rdy_n),
    .bus_abrt_n(bus_abrt_n), .bus_err_n(bus_err_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .burst_size(burst_size), .dir_rd(dir_rd), .err_status(err_status), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input int c);
    case (c)
      1: return 2;
      2: return 4;
      3: return 8;
      4: return 16;
      5: return 12;
      default: return 1;
    endcase
  endfunction

  function automatic int fit(input int n);
    if (n >= 16) return 4;
    if (n >= 12) return 5;
    if (n >= 8)  return 3;
    if (n >= 4)  return 2;
    if (n >= 2)  return 1;
    return 0;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_gnt_n = 1'b1; bus_rdy_n = 1'b1; bus_abrt_n = 1'b1; bus_err_n = 1'b1;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic xfer(input int code, input bit wr, input bit early, input int abort_at,
                      input bit stall, input bit hold_gnt);
    int total, done_w, tl, guard, rd_exp, ex;
    bit aborted, ab_now, tog, rd_pend;
    total = len_of(code); done_w = 0; aborted = 0; tog = 0; rd_pend = 0; rd_exp = 0;
    chk(req_ready, "R12 ready when idle", req_ready, 1);
    early_mode = early; req_valid = 1'b1; req_write = wr; req_code = code[2:0]; req_addr = BASE;
    if (hold_gnt) bus_gnt_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (hold_gnt) begin
      for (int i = 0; i < 3; i++) begin
        chk(bus_req_n, "R4 no request while grant low", bus_req_n, 1);
        @(negedge clk);
      end
      bus_gnt_n = 1'b1;
    end
    while (done_w < total) begin
      guard = 0;
      while (bus_req_n && guard < 8) begin @(negedge clk); guard++; end
      chk(!bus_req_n, "R4 request raised", bus_req_n, 0);
      chk(!ad_oe, "R11 float before grant", ad_oe, 0);
      bus_gnt_n = 1'b0;
      @(negedge clk);
      bus_gnt_n = 1'b1;
      ex = fit(total - done_w);
      tl = len_of(ex);
      chk(ad_oe && ad_out == 32'(BASE + 4 * done_w), done_w == 0 ? "R4 address clock" : "R6 resume address",
          ad_out, 32'(BASE + 4 * done_w));
      chk(burst_size == 3'(ex), done_w == 0 ? "R1 size code" : "R8 resume size code", burst_size, ex);
      chk(dir_rd == !wr, "R2 direction", dir_rd, !wr);
      chk(bus_req_n == (tl == 1), "R3 request in address clock", bus_req_n, tl == 1);
      bus_rdy_n = 1'b0;
      if (!early) begin
        @(negedge clk);
        chk(ad_oe == wr, "R11 drive in unsampled clock", ad_oe, wr);
        bus_rdy_n = 1'b0;
      end
      ab_now = 0;
      while (tl > 0 && !ab_now) begin
        @(negedge clk);
        if (rd_pend) begin
          chk(rd_valid && rd_idx == 5'(rd_exp) && rd_data == 32'hC300_0000 + rd_exp,
              "R5 read word", {rd_valid, rd_idx, rd_data}, {1'b1, 5'(rd_exp), 32'hC300_0000 + rd_exp});
          rd_pend = 0;
        end else begin
          chk(!rd_valid, "R9 no word before sampling", rd_valid, 0);
        end
        chk(bus_req_n == (tl == 1), "R3 request in data phase", bus_req_n, tl == 1);
        chk(ad_oe == wr, "R11 drive in data phase", ad_oe, wr);
        if (wr) chk(ad_out == 32'hA500_0000 + done_w, "R5 write word", ad_out, 32'hA500_0000 + done_w);
        ad_in = 32'hC300_0000 + done_w;
        if (abort_at == done_w && !aborted) begin
          bus_abrt_n = 1'b0; bus_rdy_n = 1'b0; aborted = 1; ab_now = 1;
          @(negedge clk);
          bus_abrt_n = 1'b1; bus_rdy_n = 1'b1;
          chk(bus_req_n && !ad_oe, "R6 bus released after abort", {bus_req_n, ad_oe}, 2'b10);
          chk(!rd_valid && !xfer_done, "R7 ready ignored under abort", {rd_valid, xfer_done}, 0);
        end else if (stall && !tog) begin
          bus_rdy_n = 1'b1; tog = 1;
        end else begin
          bus_rdy_n = 1'b0; tog = 0;
          if (!wr) begin rd_pend = 1; rd_exp = done_w; end
          done_w++; tl--;
        end
      end
      if (!ab_now) begin
        @(negedge clk);
        bus_rdy_n = 1'b1;
        if (rd_pend) begin
          chk(rd_valid && rd_idx == 5'(rd_exp) && rd_data == 32'hC300_0000 + rd_exp,
              "R5 last read word", {rd_valid, rd_idx, rd_data}, {1'b1, 5'(rd_exp), 32'hC300_0000 + rd_exp});
          rd_pend = 0;
        end
        chk(xfer_done == (done_w == total), "R12 done pulse", xfer_done, done_w == total);
        chk(bus_req_n && !ad_oe, "R11 float after tenure", {bus_req_n, ad_oe}, 2'b10);
      end
    end
    @(negedge clk);
    chk(!xfer_done && req_ready, "R12 single pulse then idle", {xfer_done, req_ready}, 2'b01);
  endtask

  task automatic err_test(input bit mask);
    int guard;
    err_mask = mask;
    early_mode = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_code = 3'd3; req_addr = BASE;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (bus_req_n && guard < 8) begin @(negedge clk); guard++; end
    bus_gnt_n = 1'b0;
    @(negedge clk);
    bus_gnt_n = 1'b1; bus_rdy_n = 1'b0;
    @(negedge clk);
    bus_err_n = 1'b0;
    @(negedge clk);
    bus_err_n = 1'b1;
    chk(err_status, "R10 sticky error set", err_status, 1);
    chk(irq == !mask, "R10 interrupt vs mask", irq, !mask);
    for (int i = 0; i < 4; i++) begin
      chk(bus_req_n && !ad_oe && !req_ready, "R10 halted", {bus_req_n, ad_oe, req_ready}, 3'b100);
      @(negedge clk);
    end
    chk(err_status, "R10 error stays set", err_status, 1);
    bus_rdy_n = 1'b1;
    do_reset();
    chk(!err_status && !irq, "R10 cleared only by reset", {err_status, irq}, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    chk(dir_rd == 1'b1, "R2 reset direction", dir_rd, 1);
    chk(bus_req_n && !ad_oe, "R2 reset request and bus", {bus_req_n, ad_oe}, 2'b10);
    chk(burst_size == 3'd0, "R2 reset size", burst_size, 0);
    chk(!err_status && !irq && req_ready, "R2 reset status", {err_status, irq, req_ready}, 3'b001);
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 2; w++)
        for (int e = 0; e < 2; e++)
          xfer(c, w[0], e[0], -1, c[0] ^ e[0], 1'b0);
    xfer(4, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    xfer(4, 1'b0, 1'b1, 5, 1'b1, 1'b0);
    xfer(4, 1'b1, 1'b1, 15, 1'b0, 1'b0);
    xfer(5, 1'b0, 1'b0, 3, 1'b0, 1'b0);
    xfer(3, 1'b1, 1'b0, 7, 1'b1, 1'b0);
    xfer(2, 1'b0, 1'b1, 2, 1'b0, 1'b1);
    xfer(1, 1'b1, 1'b0, -1, 1'b0, 1'b1);
    err_test(1'b0);
    err_test(1'b1);
    summary();
  end
endmodule